// File: doc/BRIEF.md
# Three-Cache MESI Coherence Controller

The block tracks the coherence state of one shared cache line held by three processor-side caches on a snooping bus, using the four-state MESI protocol. On each clock it accepts at most one processor reference. The reference carries a processor number (1 to 3), a read or write flag, and a word select. The line holds two words, A and B. Both words share one coherence state per cache, so the word select never changes the outcome. This is how false sharing between the two words appears.

For every accepted reference the block produces four results:
- the next state of all three caches;
- the bus message issued;
- a hit flag;
- the cost of the reference in cycles.

The cost model separates a line supplied by a peer cache from a line supplied by memory. A 16-bit accumulator sums the costs of all references since reset.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset, every cache is Invalid (code 0), `valid_o`, `hit_o`, `bus_o` and `cost_o` are 0, and `total_o` is 0. State codes are I=0, S=1, E=2, M=3. Cache of processor p sits in `st_o[2p-1:2p-2]`.
- R2: At any time at most one cache is in M or E, and when one is, every other cache is Invalid.
- R3: A read by a cache in S, E or M is a hit: no bus message (code 0), cost 1, and no state changes.
- R4: A read miss while no other cache holds the line issues BusRd (code 1), costs 150, and leaves the requester in E.
- R5: A read miss while another cache holds the line in M or E issues BusRd and costs 50. The supplier and the requester both end in S.
- R6: A read miss while the other valid copies are all S issues BusRd and costs 150. The requester ends in S and the peers are unchanged.
- R7: A write by a cache in S issues BusUpgr (code 3) and costs 10. It counts as a hit. The requester goes to M and every other cache goes to I.
- R8: A write by a cache in I is a miss and issues BusRdX (code 2). It costs 50 when any other cache holds a valid copy and 150 otherwise. The requester ends in M and all others in I.
- R9: A write by a cache in E or M is a hit with no bus message and costs 1. The requester ends in M.
- R10: The word select (`req_word_i`, 0 for A and 1 for B) has no effect on states, message, hit or cost.
- R11: Results appear on the outputs one clock after the reference, with `valid_o` high. On that same edge `total_o` grows by `cost_o`, modulo 2^16.
- R12: A cycle with `req_valid_i` low, or with a processor number of 0 or above 3, is ignored. States and total are unchanged and `valid_o` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | A reference is presented this cycle |
| req_pid_i | input | 2 | Processor number, 1 to 3 |
| req_wr_i | input | 1 | 1 for a write, 0 for a read |
| req_word_i | input | 1 | Word select, 0 = A, 1 = B |
| st_o | output | 6 | Per-cache coherence state, two bits per cache |
| bus_o | output | 2 | Bus message: 0 none, 1 BusRd, 2 BusRdX, 3 BusUpgr |
| hit_o | output | 1 | Requester held a valid copy |
| cost_o | output | 8 | Cycle cost of the last reference |
| total_o | output | 16 | Running sum of costs |
| valid_o | output | 1 | Outputs describe a reference accepted last cycle |

## Verification
Two things can coincide in one cycle. A reference arrives on the same clock edge at which the previous reference's transition is written into the state registers. It must also be priced against that freshly written state. The bench provokes this by issuing a ten-reference mixed stream back to back, with no idle cycle between references. Several references in that stream depend on the state change made by the one just before. Examples are an upgrade followed by a peer read miss, and a downgrade followed by a write. Each step's states, message, hit and cost, and the running total, are compared one clock later against values derived by hand from the protocol rules.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } mesi_t;

  typedef enum logic [1:0] {
    BUS_NONE = 2'd0,
    BUS_RD   = 2'd1,
    BUS_RDX  = 2'd2,
    BUS_UPGR = 2'd3
  } bus_t;
endpackage

// File: rtl/mesi_xfer.sv
module mesi_xfer
  import mesi_pkg::*;
#(
  parameter int N_CACHE    = 3,
  parameter int COST_W     = 8,
  parameter int HIT_COST   = 1,
  parameter int UPGR_COST  = 10,
  parameter int PEER_COST  = 50,
  parameter int MEM_COST   = 150,
  localparam int IDX_W     = (N_CACHE > 1) ? $clog2(N_CACHE) : 1
) (
  input  mesi_t              st_i  [N_CACHE],
  input  logic [IDX_W-1:0]   idx_i,
  input  logic               wr_i,
  output mesi_t              st_o  [N_CACHE],
  output bus_t               bus_o,
  output logic               hit_o,
  output logic [COST_W-1:0]  cost_o
);
  logic [N_CACHE-1:0] peer_vld, peer_own;
  mesi_t cur, req_nx;
  logic  inv, dgr;

  for (genvar i = 0; i < N_CACHE; i++) begin : g_peer
    logic is_req;
    assign is_req      = (idx_i == IDX_W'(i));
    assign peer_vld[i] = !is_req && (st_i[i] != ST_I);
    assign peer_own[i] = !is_req && ((st_i[i] == ST_M) || (st_i[i] == ST_E));
    always_comb begin
      if (is_req)                                            st_o[i] = req_nx;
      else if (inv)                                          st_o[i] = ST_I;
      else if (dgr && (st_i[i] == ST_M || st_i[i] == ST_E))  st_o[i] = ST_S;
      else                                                   st_o[i] = st_i[i];
    end
  end

  always_comb begin
    cur    = st_i[idx_i];
    req_nx = cur;
    bus_o  = BUS_NONE;
    hit_o  = (cur != ST_I);
    cost_o = COST_W'(HIT_COST);
    inv    = 1'b0;
    dgr    = 1'b0;
    if (!wr_i) begin
      if (cur == ST_I) begin
        bus_o  = BUS_RD;
        dgr    = 1'b1;
        // only an exclusive owner supplies; clean sharers leave it to memory
        cost_o = (|peer_own) ? COST_W'(PEER_COST) : COST_W'(MEM_COST);
        req_nx = (|peer_vld) ? ST_S : ST_E;
      end
    end else begin
      unique case (cur)
        ST_M: req_nx = ST_M;
        ST_E: req_nx = ST_M;
        ST_S: begin
          bus_o  = BUS_UPGR;
          cost_o = COST_W'(UPGR_COST);
          inv    = 1'b1;
          req_nx = ST_M;
        end
        default: begin
          bus_o  = BUS_RDX;
          cost_o = (|peer_vld) ? COST_W'(PEER_COST) : COST_W'(MEM_COST);
          inv    = 1'b1;
          req_nx = ST_M;
        end
      endcase
    end
  end
endmodule

// File: rtl/mesi_cost_acc.sv
module mesi_cost_acc #(
  parameter int COST_W = 8,
  parameter int TOT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              add_i,
  input  logic [COST_W-1:0] cost_i,
  output logic [TOT_W-1:0]  total_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    total_o <= '0;
    else if (add_i) total_o <= total_o + TOT_W'(cost_i);
  end
endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_pkg::*;
#(
  parameter int N_CACHE   = 3,
  parameter int COST_W    = 8,
  parameter int TOT_W     = 16,
  parameter int HIT_COST  = 1,
  parameter int UPGR_COST = 10,
  parameter int PEER_COST = 50,
  parameter int MEM_COST  = 150,
  localparam int PID_W    = $clog2(N_CACHE + 1),
  localparam int IDX_W    = (N_CACHE > 1) ? $clog2(N_CACHE) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic [PID_W-1:0]     req_pid_i,
  input  logic                 req_wr_i,
  input  logic                 req_word_i,
  output logic [2*N_CACHE-1:0] st_o,
  output logic [1:0]           bus_o,
  output logic                 hit_o,
  output logic [COST_W-1:0]    cost_o,
  output logic [TOT_W-1:0]     total_o,
  output logic                 valid_o
);
  mesi_t st_q [N_CACHE];
  mesi_t st_nx[N_CACHE];
  bus_t  bus_nx;
  logic  hit_nx;
  logic [COST_W-1:0] cost_nx;
  logic [PID_W-1:0]  pid_m1;
  logic [IDX_W-1:0]  idx;
  logic              take;
  logic              unused_word;

  // both words map onto one state; select is deliberately dropped
  assign unused_word = req_word_i;

  assign pid_m1 = req_pid_i - PID_W'(1);
  assign idx    = IDX_W'(pid_m1);
  assign take   = req_valid_i && (req_pid_i != '0) && (req_pid_i <= PID_W'(N_CACHE));

  mesi_xfer #(
    .N_CACHE(N_CACHE), .COST_W(COST_W), .HIT_COST(HIT_COST),
    .UPGR_COST(UPGR_COST), .PEER_COST(PEER_COST), .MEM_COST(MEM_COST)
  ) u_xfer (
    .st_i  (st_q),
    .idx_i (idx),
    .wr_i  (req_wr_i),
    .st_o  (st_nx),
    .bus_o (bus_nx),
    .hit_o (hit_nx),
    .cost_o(cost_nx)
  );

  for (genvar i = 0; i < N_CACHE; i++) begin : g_st
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   st_q[i] <= ST_I;
      else if (take) st_q[i] <= st_nx[i];
    end
    assign st_o[2*i +: 2] = st_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      bus_o   <= BUS_NONE;
      hit_o   <= 1'b0;
      cost_o  <= '0;
    end else begin
      valid_o <= take;
      bus_o   <= take ? bus_nx  : BUS_NONE;
      hit_o   <= take && hit_nx;
      cost_o  <= take ? cost_nx : '0;
    end
  end

  mesi_cost_acc #(.COST_W(COST_W), .TOT_W(TOT_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .add_i  (take),
    .cost_i (cost_nx),
    .total_o(total_o)
  );
endmodule

// File: rtl/mesi_snoop_chk.sv
module mesi_snoop_chk #(
  parameter int N_CACHE   = 3,
  parameter int COST_W    = 8,
  parameter int TOT_W     = 16,
  parameter int HIT_COST  = 1,
  parameter int UPGR_COST = 10,
  localparam int PID_W    = $clog2(N_CACHE + 1)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_valid_i,
  input logic [PID_W-1:0]     req_pid_i,
  input logic [2*N_CACHE-1:0] st_o,
  input logic [1:0]           bus_o,
  input logic                 hit_o,
  input logic [COST_W-1:0]    cost_o,
  input logic [TOT_W-1:0]     total_o,
  input logic                 valid_o
);
  logic [N_CACHE-1:0] own, vld;
  logic bad_req;

  for (genvar i = 0; i < N_CACHE; i++) begin : g_c
    assign own[i] = st_o[2*i+1];
    assign vld[i] = (st_o[2*i +: 2] != 2'd0);
  end

  assign bad_req = req_valid_i && ((req_pid_i == '0) || (req_pid_i > PID_W'(N_CACHE)));

  p_one_owner_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(own));
  p_owner_alone_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|own) |-> ($countones(vld) == 1));
  p_quiet_hit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && bus_o == 2'd0) |-> (hit_o && cost_o == COST_W'(HIT_COST)));
  p_upgr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && bus_o == 2'd3) |-> (hit_o && cost_o == COST_W'(UPGR_COST)));
  p_miss_fetch_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !hit_o) |-> (bus_o == 2'd1 || bus_o == 2'd2));
  p_acc_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> (total_o == $past(total_o)) || valid_o);
  p_acc_step_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (total_o == $past(total_o) + TOT_W'(cost_o)));
  p_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (total_o == $past(total_o)));
  p_bad_pid_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_req |=> !valid_o);
endmodule

bind mesi_snoop_ctrl mesi_snoop_chk #(
  .N_CACHE(N_CACHE), .COST_W(COST_W), .TOT_W(TOT_W),
  .HIT_COST(HIT_COST), .UPGR_COST(UPGR_COST)
) u_chk (.*);

// File: tb/sim_mesi_snoop_ctrl.sv
`timescale 1ns/1ps
module sim_mesi_snoop_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_valid_i = 1'b0;
  logic [1:0] req_pid_i = '0;
  logic       req_wr_i = 1'b0;
  logic       req_word_i = 1'b0;
  logic [5:0] st_o;
  logic [1:0] bus_o;
  logic       hit_o;
  logic [7:0] cost_o;
  logic [15:0] total_o;
  logic       valid_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  localparam logic [1:0] I = 2'd0, S = 2'd1, E = 2'd2, M = 2'd3;
  localparam logic [1:0] NB = 2'd0, RD = 2'd1, RDX = 2'd2, UPG = 2'd3;

  always #10 clk_i = ~clk_i;

  mesi_snoop_ctrl u0 (.*);

  function automatic logic [5:0] pk(logic [1:0] p1, logic [1:0] p2, logic [1:0] p3);
    return {p3, p2, p1};
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    req_valid_i = 1'b0;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  // drive at a negedge, check at the next negedge (one edge later)
  task automatic do_ref(string tag, int pid, bit wr, bit word,
                        logic [5:0] est, logic [1:0] ebus, bit ehit,
                        int ecost, int etot);
    req_valid_i = 1'b1;
    req_pid_i   = 2'(pid);
    req_wr_i    = wr;
    req_word_i  = word;
    @(negedge clk_i);
    chk({tag, " valid"}, valid_o, 1);
    chk({tag, " state"}, st_o, est);
    chk({tag, " bus"},   bus_o, ebus);
    chk({tag, " hit"},   hit_o, ehit);
    chk({tag, " cost"},  cost_o, ecost);
    chk({tag, " total"}, total_o, etot);
    req_valid_i = 1'b0;
  endtask

  task automatic do_ign(string tag, bit vld, int pid, logic [5:0] est, int etot);
    req_valid_i = vld;
    req_pid_i   = 2'(pid);
    req_wr_i    = 1'b1;
    @(negedge clk_i);
    chk({tag, " valid"}, valid_o, 0);
    chk({tag, " state"}, st_o, est);
    chk({tag, " total"}, total_o, etot);
    req_valid_i = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 state", st_o, 0);
    chk("R1 valid", valid_o, 0);
    chk("R1 bus",   bus_o, 0);
    chk("R1 hit",   hit_o, 0);
    chk("R1 cost",  cost_o, 0);
    chk("R1 total", total_o, 0);
  endtask

  // back-to-back mixed stream, each step priced on the state just written
  task automatic t_stream();
    do_reset();
    do_ref("s1 R4 r1A",  1, 0, 0, pk(E, I, I), RD,  0, 150, 150);
    do_ref("s2 R5 r3B",  3, 0, 1, pk(S, I, S), RD,  0, 50,  200);
    do_ref("s3 R7 w3B",  3, 1, 1, pk(I, I, M), UPG, 1, 10,  210);
    do_ref("s4 R5 r1A",  1, 0, 0, pk(S, I, S), RD,  0, 50,  260);
    do_ref("s5 R6 r2A",  2, 0, 0, pk(S, S, S), RD,  0, 150, 410);
    do_ref("s6 R7 w1B",  1, 1, 1, pk(M, I, I), UPG, 1, 10,  420);
    do_ref("s7 R5 r2B",  2, 0, 1, pk(S, S, I), RD,  0, 50,  470);
    do_ref("s8 R7 w1B",  1, 1, 1, pk(M, I, I), UPG, 1, 10,  480);
    do_ref("s9 R8 w3A",  3, 1, 0, pk(I, I, M), RDX, 0, 50,  530);
    do_ref("s10 R5 r1A", 1, 0, 0, pk(S, I, S), RD,  0, 50,  580);
    @(negedge clk_i);
    chk("R11 final total", total_o, 580);
    chk("R12 idle valid", valid_o, 0);
  endtask

  task automatic t_cold_write();
    do_reset();
    do_ref("R8 cold w2A",  2, 1, 0, pk(I, M, I), RDX, 0, 150, 150);
    do_ref("R3 R10 r2B",   2, 0, 1, pk(I, M, I), NB,  1, 1,   151);
    do_ref("R9 w2A in M",  2, 1, 0, pk(I, M, I), NB,  1, 1,   152);
  endtask

  task automatic t_excl_write();
    do_reset();
    do_ref("R4 r1A",       1, 0, 0, pk(E, I, I), RD,  0, 150, 150);
    do_ref("R3 r1B in E",  1, 0, 1, pk(E, I, I), NB,  1, 1,   151);
    do_ref("R9 w1B in E",  1, 1, 1, pk(M, I, I), NB,  1, 1,   152);
    do_ref("R8 w3A peer",  3, 1, 0, pk(I, I, M), RDX, 0, 50,  202);
  endtask

  task automatic t_word();
    do_reset();
    do_ref("R10 r2B", 2, 0, 1, pk(I, E, I), RD, 0, 150, 150);
    do_reset();
    do_ref("R10 r2A", 2, 0, 0, pk(I, E, I), RD, 0, 150, 150);
    do_ref("R10 w1B", 1, 1, 1, pk(M, I, I), RDX, 0, 50, 200);
    do_reset();
    do_ref("R10 r2A'", 2, 0, 0, pk(I, E, I), RD, 0, 150, 150);
    do_ref("R10 w1A", 1, 1, 0, pk(M, I, I), RDX, 0, 50, 200);
  endtask

  task automatic t_ignore();
    do_reset();
    do_ref("R4 r3A", 3, 0, 0, pk(I, I, E), RD, 0, 150, 150);
    do_ign("R12 pid0",   1, 0, pk(I, I, E), 150);
    do_ign("R12 novalid", 0, 1, pk(I, I, E), 150);
    do_ref("R8 w1A after ignore", 1, 1, 0, pk(M, I, I), RDX, 0, 50, 200);
  endtask

  initial begin
    t_reset();
    t_stream();
    t_cold_write();
    t_excl_write();
    t_word();
    t_ignore();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
      $finish;
    end
  end
endmodule